// File: doc/BRIEF.md
# Crystal Frequency Calibration Controller

This block estimates the frequency error of a free-running local crystal by comparing it against a trusted once-per-second time reference. The crystal side supplies a 1 kHz tick. The block divides this tick down to centiseconds and counts them in a wrapped counter. It also counts elapsed minutes from the same tick. The reference side supplies a second tick that carries the decoded second and the units digit of the minute, a sync flag and a flag that marks a pending leap second.

Calibration has two independent state bits. One tracks whether the reference is trustworthy (qualified). The other tracks whether a measurement is in progress (running). Transitions between running and waiting happen only at reference second 5. A measurement ends when its observation window is long enough. The block then divides the scaled phase error by the elapsed minutes in a multi-cycle sequential divider, updates a signed trim word for the oscillator and pulses a result-ready strobe so that an external store can save the result. The radio decoder, the oscillator and the storage are outside the block.

Top module: `xtal_trim_ctrl`

## Requirements
- R1: After synchronous reset, `trim_word`, `precision`, `phase_dev` and `result_ready` are 0, and `cal_state` is 0 (waiting, unqualified).
- R2: `cal_state[0]` (qualified) equals the value `ref_sync` had in the previous cycle.
- R3: `cal_state[1]` (running) changes only on a `sec_tick` with `ref_sec` = 5. From waiting with qualified = 1, such a tick sets running, clears the centisecond, prescaler and minute counters, and captures `ref_min_units` as the start minute. With qualified = 0, the block stays waiting.
- R4: On every `sec_tick`, `phase_dev` takes the value cs − CS_PER_SEC·(ref_sec − 5) − 60·CS_PER_SEC·(ref_min_units − start_minute). The value is evaluated from the counter state before that edge and is wrapped by ±W into (−W/2, W/2], where W = 600·CS_PER_SEC.
- R5: When running and qualified at second 5, a measurement finishes if (minutes ≥ TAU_MIN and |dev| ≥ 5) or minutes ≥ TAU_MAX. Finishing returns the block to waiting. Otherwise the block keeps running.
- R6: When running and unqualified at second 5, the block returns to waiting once minutes ≥ TAU_MAX, and keeps running below that.
- R7: On finishing, the new trim is the old trim minus (GAIN·dev)/minutes, with the quotient truncated toward zero, and the result is clamped to ±MAX_ADJ.
- R8: On finishing, `precision` becomes (GAIN − 1 + minutes)/minutes, and is never less than 1.
- R9: A `sec_tick` at second 5 with `leap_pending` = 1 forces waiting and produces no result.
- R10: `result_ready` is a single-cycle pulse, raised exactly once per finished measurement and together with the new trim. The trim is unchanged while the divider is busy.
- R11: Every MS_PER_CS crystal ticks advance the centisecond counter, which wraps from W − 1 to 0. Every 60·CS_PER_SEC centiseconds advance the minute counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per crystal millisecond |
| sec_tick | input | 1 | One-cycle pulse per reference second |
| ref_sec | input | 6 | Reference second, valid with sec_tick |
| ref_min_units | input | 4 | Reference minute units digit, valid with sec_tick |
| ref_sync | input | 1 | Reference is in sync |
| leap_pending | input | 1 | Leap second announced |
| trim_word | output | TRIM_W | Signed oscillator trim |
| precision | output | 16 | Confirmed precision of the last result |
| phase_dev | output | 16 | Signed wrapped phase deviation in centiseconds |
| cal_state | output | 2 | Bit 1 running, bit 0 qualified |
| result_ready | output | 1 | One-cycle pulse when a new trim is available |

## Verification
The bench uses a scaled configuration: two milliseconds per centisecond, four centiseconds per second, tau_min 2 and tau_max 4. It sweeps every minute digit against several seconds after the counter has wrapped. A design that wrapped at the wrong boundary, or used the wrong half-open range, would report deviations shifted by one full span. It drives deviations of ±7 at two minutes, where truncation toward zero gives −9334 rather than −9335, and it drives deviations that exceed the ±MAX_ADJ limit in both directions. A design that floored the quotient, or that failed to clamp, would leave a trim one count off or out of range. The bench also runs window boundaries: |dev| ≥ 5 one minute short of tau_min, a small deviation at tau_max, an unqualified abort and a leap second. A design with wrong gating would finish early, hang in running or emit a spurious result.

// File: rtl/xtal_trim_pkg.sv
package xtal_trim_pkg;

    localparam int CAL_SECOND  = 5;
    localparam int DEV_TRIGGER = 5;

    typedef struct packed {
        logic running;
        logic qualified;
    } cal_state_t;

    // fold a raw deviation into (-span/2, span/2]
    function automatic int wrap_phase(input int raw, input int span);
        int v;
        v = raw;
        for (int i = 0; i < 3; i++) begin
            if (v > span / 2)
                v = v - span;
            else if (v <= -(span / 2))
                v = v + span;
        end
        return v;
    endfunction

    function automatic int clamp_sym(input int v, input int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic int abs_int(input int v);
        return (v < 0) ? -v : v;
    endfunction

endpackage

// File: rtl/xtal_tick_counters.sv
module xtal_tick_counters #(
    parameter int MS_PER_CS  = 10,
    parameter int CS_PER_MIN = 6000,
    parameter int CS_WRAP    = 60000,
    parameter int CS_W       = 16,
    parameter int MIN_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             ms_tick,
    output logic [CS_W-1:0]  cs_cnt,
    output logic [MIN_W-1:0] min_cnt
);
    localparam int PRE_W = $clog2(MS_PER_CS + 1);
    localparam int SUB_W = $clog2(CS_PER_MIN + 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [SUB_W-1:0] sub_cnt;
    logic             cs_step;

    assign cs_step = ms_tick && (pre_cnt == PRE_W'(MS_PER_CS - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
            cs_cnt  <= '0;
            min_cnt <= '0;
        end else if (ms_tick) begin
            pre_cnt <= cs_step ? '0 : pre_cnt + 1'b1;
            if (cs_step) begin
                cs_cnt  <= (cs_cnt == CS_W'(CS_WRAP - 1)) ? '0 : cs_cnt + 1'b1;
                if (sub_cnt == SUB_W'(CS_PER_MIN - 1)) begin
                    sub_cnt <= '0;
                    if (min_cnt != {MIN_W{1'b1}})
                        min_cnt <= min_cnt + 1'b1;
                end else begin
                    sub_cnt <= sub_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xtal_seq_div.sv
module xtal_seq_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [CNT_W-1:0] cnt;
    logic [DEN_W-1:0] rem;
    logic [NUM_W-1:0] acc;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             ge;

    assign trial = {rem, acc[NUM_W-1]};
    assign ge    = trial >= {1'b0, den};
    assign diff  = trial - {1'b0, den};
    assign quot  = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            rem  <= '0;
            acc  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                acc  <= num;
                rem  <= '0;
                cnt  <= CNT_W'(NUM_W);
                busy <= 1'b1;
            end else if (busy) begin
                acc <= {acc[NUM_W-2:0], ge};
                rem <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xtal_trim_ctrl.sv
module xtal_trim_ctrl
    import xtal_trim_pkg::*;
#(
    parameter int MS_PER_CS  = 10,
    parameter int CS_PER_SEC = 100,
    parameter int TAU_MIN    = 16,
    parameter int TAU_MAX    = 5333,
    parameter int MAX_ADJ    = 30000,
    parameter int GAIN       = 2667,
    parameter int TRIM_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ms_tick,
    input  logic                     sec_tick,
    input  logic [5:0]               ref_sec,
    input  logic [3:0]               ref_min_units,
    input  logic                     ref_sync,
    input  logic                     leap_pending,
    output logic signed [TRIM_W-1:0] trim_word,
    output logic [15:0]              precision,
    output logic signed [15:0]       phase_dev,
    output logic [1:0]               cal_state,
    output logic                     result_ready
);
    localparam int CS_PER_MIN = CS_PER_SEC * 60;
    localparam int CS_WRAP    = CS_PER_MIN * 10;
    localparam int CS_W       = $clog2(CS_WRAP);
    localparam int MIN_W      = 16;
    localparam int NUM_W      = 32;
    localparam int LANES      = 2;

    cal_state_t       st;
    logic [3:0]       start_min;
    logic [CS_W-1:0]  cs_cnt;
    logic [MIN_W-1:0] min_cnt;
    logic             dev_neg;

    int   dev_now;
    int   dev_mag;
    int   minutes;
    logic cal_tick;
    logic finish_ok;
    logic clear_cnt;
    logic div_start;
    logic div_busy;
    logic div_done;

    logic [NUM_W-1:0] lane_num  [LANES];
    logic [NUM_W-1:0] lane_quot [LANES];
    logic [LANES-1:0] lane_busy;
    logic [LANES-1:0] lane_done;
    logic [MIN_W-1:0] div_den;

    int   offset;
    int   next_trim;

    assign cal_state = st;

    xtal_tick_counters #(
        .MS_PER_CS (MS_PER_CS),
        .CS_PER_MIN(CS_PER_MIN),
        .CS_WRAP   (CS_WRAP),
        .CS_W      (CS_W),
        .MIN_W     (MIN_W)
    ) i_counters (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_cnt),
        .ms_tick(ms_tick),
        .cs_cnt (cs_cnt),
        .min_cnt(min_cnt)
    );

    // phase error against the reference second and minute digit
    always_comb begin
        int raw;
        raw = int'(cs_cnt)
            - CS_PER_SEC * (int'(ref_sec) - CAL_SECOND)
            - CS_PER_MIN * (int'(ref_min_units) - int'(start_min));
        dev_now = wrap_phase(raw, CS_WRAP);
        dev_mag = abs_int(dev_now);
        minutes = int'(min_cnt);
    end

    assign cal_tick  = sec_tick && (int'(ref_sec) == CAL_SECOND);
    assign finish_ok = (minutes >= TAU_MIN && dev_mag >= DEV_TRIGGER) || (minutes >= TAU_MAX);
    assign clear_cnt = cal_tick && !leap_pending && !st.running && st.qualified;
    assign div_start = cal_tick && !leap_pending && st.running && st.qualified
                       && finish_ok && !div_busy;

    // lane 0: scaled deviation / minutes, lane 1: rounded-up precision
    assign div_den     = (min_cnt == '0) ? MIN_W'(1) : min_cnt;
    assign lane_num[0] = NUM_W'(GAIN * dev_mag);
    assign lane_num[1] = NUM_W'(GAIN - 1 + minutes);
    assign div_busy    = |lane_busy;
    assign div_done    = &lane_done;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xtal_seq_div #(
            .NUM_W(NUM_W),
            .DEN_W(MIN_W)
        ) i_div (
            .clk  (clk),
            .rst  (rst),
            .start(div_start),
            .num  (lane_num[g]),
            .den  (div_den),
            .busy (lane_busy[g]),
            .done (lane_done[g]),
            .quot (lane_quot[g])
        );
    end

    always_comb begin
        offset    = dev_neg ? -int'(lane_quot[0]) : int'(lane_quot[0]);
        next_trim = clamp_sym(int'(trim_word) - offset, MAX_ADJ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= '0;
            start_min    <= '0;
            phase_dev    <= '0;
            trim_word    <= '0;
            precision    <= '0;
            result_ready <= 1'b0;
            dev_neg      <= 1'b0;
        end else begin
            st.qualified <= ref_sync;
            result_ready <= 1'b0;

            if (sec_tick)
                phase_dev <= 16'(dev_now);

            if (cal_tick) begin
                if (leap_pending) begin
                    st.running <= 1'b0;
                end else if (st.running) begin
                    if (st.qualified) begin
                        if (div_start)
                            st.running <= 1'b0;
                    end else if (minutes >= TAU_MAX) begin
                        st.running <= 1'b0;
                    end
                end else if (st.qualified) begin
                    st.running <= 1'b1;
                    start_min  <= ref_min_units;
                end
            end

            if (div_start)
                dev_neg <= (dev_now < 0);

            if (div_done) begin
                trim_word    <= TRIM_W'(next_trim);
                precision    <= (lane_quot[1] == '0) ? 16'd1 : 16'(lane_quot[1]);
                result_ready <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/xtal_trim_ctrl_chk.sv
module xtal_trim_ctrl_chk #(
    parameter int MAX_ADJ = 30000,
    parameter int CS_WRAP = 60000,
    parameter int TRIM_W  = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sec_tick,
    input logic [5:0]               ref_sec,
    input logic                     ref_sync,
    input logic                     leap_pending,
    input logic signed [TRIM_W-1:0] trim_word,
    input logic [15:0]              precision,
    input logic signed [15:0]       phase_dev,
    input logic [1:0]               cal_state,
    input logic                     result_ready,
    input logic                     div_busy
);

    AST_QUAL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cal_state[0] == $past(ref_sync)));                         // R2

    AST_RUN_ONLY_AT_SECOND: assert property (@(posedge clk) disable iff (rst)
        !(sec_tick && ref_sec == 6'd5) |=> $stable(cal_state[1]));                  // R3

    AST_DEV_WRAPPED: assert property (@(posedge clk) disable iff (rst)
        (int'(phase_dev) > -(CS_WRAP / 2)) && (int'(phase_dev) <= CS_WRAP / 2));    // R4

    AST_TRIM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(trim_word) <= MAX_ADJ) && (int'(trim_word) >= -MAX_ADJ));             // R7

    AST_PREC_POSITIVE: assert property (@(posedge clk) disable iff (rst)
        result_ready |-> (precision != 16'd0));                                      // R8

    AST_LEAP_STOPS: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && ref_sec == 6'd5 && leap_pending) |=> !cal_state[1]);           // R9

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        result_ready |=> !result_ready);                                             // R10

    AST_TRIM_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> $stable(trim_word));                                            // R10

endmodule

bind xtal_trim_ctrl xtal_trim_ctrl_chk #(
    .MAX_ADJ(MAX_ADJ),
    .CS_WRAP(CS_WRAP),
    .TRIM_W (TRIM_W)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .sec_tick    (sec_tick),
    .ref_sec     (ref_sec),
    .ref_sync    (ref_sync),
    .leap_pending(leap_pending),
    .trim_word   (trim_word),
    .precision   (precision),
    .phase_dev   (phase_dev),
    .cal_state   (cal_state),
    .result_ready(result_ready),
    .div_busy    (div_busy)
);

// File: tb/test_xtal_trim_ctrl.sv
module test_xtal_trim_ctrl;

    localparam int DIV   = 2;
    localparam int CPS   = 4;
    localparam int CPM   = CPS * 60;
    localparam int W     = CPM * 10;
    localparam int TMIN  = 2;
    localparam int TMAX  = 4;
    localparam int MAXA  = 20000;
    localparam int GAIN  = 2667;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0;
    logic        sec_tick = 1'b0;
    logic [5:0]  ref_sec = '0;
    logic [3:0]  ref_min_units = '0;
    logic        ref_sync = 1'b0;
    logic        leap_pending = 1'b0;
    logic signed [15:0] trim_word;
    logic [15:0] precision;
    logic signed [15:0] phase_dev;
    logic [1:0]  cal_state;
    logic        result_ready;

    int errors = 0;
    int checks = 0;

    // bench model of the specification
    int  m_ms = 0;
    int  m_start = 0;
    bit  m_run = 0;
    bit  m_q = 0;
    int  m_trim = 0;
    int  m_prec = 0;

    always #2 clk = ~clk;

    xtal_trim_ctrl #(
        .MS_PER_CS (DIV),
        .CS_PER_SEC(CPS),
        .TAU_MIN   (TMIN),
        .TAU_MAX   (TMAX),
        .MAX_ADJ   (MAXA),
        .GAIN      (GAIN),
        .TRIM_W    (16)
    ) i_xtal_trim_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ms_tick      (ms_tick),
        .sec_tick     (sec_tick),
        .ref_sec      (ref_sec),
        .ref_min_units(ref_min_units),
        .ref_sync     (ref_sync),
        .leap_pending (leap_pending),
        .trim_word    (trim_word),
        .precision    (precision),
        .phase_dev    (phase_dev),
        .cal_state    (cal_state),
        .result_ready (result_ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        ms_tick = 1'b1;
        repeat (n) step();
        ms_tick = 1'b0;
        m_ms += n;
    endtask

    task automatic set_sync(input bit v);
        ref_sync = v;
        step();
        m_q = v;
    endtask

    function automatic int wrapw(input int v);
        int r;
        r = v;
        for (int i = 0; i < 3; i++) begin
            if (r > W / 2) r -= W;
            else if (r <= -(W / 2)) r += W;
        end
        return r;
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic cal_tick(input int s, input int m, input bit leap, input string tag);
        int d, mins, cs, pulses, got_trim, got_prec, nt;
        bit fin, nrun, start_new;
        cs   = (m_ms / DIV) % W;
        mins = (m_ms / DIV) / CPM;
        d    = wrapw(cs - CPS * (s - 5) - CPM * (m - m_start));
        fin = 0; nrun = m_run; start_new = 0;
        if (s == 5) begin
            if (leap) nrun = 0;
            else if (m_run) begin
                if (m_q) begin
                    if ((mins >= TMIN && absi(d) >= 5) || mins >= TMAX) begin
                        fin = 1; nrun = 0;
                    end
                end else if (mins >= TMAX) nrun = 0;
            end else if (m_q) begin
                nrun = 1; start_new = 1;
            end
        end
        ref_sec = 6'(s); ref_min_units = 4'(m); leap_pending = leap; sec_tick = 1'b1;
        step();
        sec_tick = 1'b0; leap_pending = 1'b0;
        check("R4 phase_dev", int'(phase_dev), d);
        check({tag, " cal_state"}, int'(cal_state), {30'd0, nrun, m_q});
        check("R10 trim held during divide", int'(trim_word), m_trim);
        m_run = nrun;
        if (start_new) begin m_ms = 0; m_start = m; end
        if (fin) begin
            nt = m_trim - (GAIN * d) / mins;
            if (nt > MAXA) nt = MAXA;
            if (nt < -MAXA) nt = -MAXA;
            m_trim = nt;
            m_prec = (GAIN - 1 + mins) / mins;
            if (m_prec < 1) m_prec = 1;
        end
        pulses = 0; got_trim = 0; got_prec = 0;
        for (int i = 0; i < 40; i++) begin
            if (result_ready) begin
                pulses++;
                got_trim = int'(trim_word);
                got_prec = int'(precision);
            end
            step();
        end
        check("R10 result_ready pulses", pulses, fin ? 1 : 0);
        if (fin) begin
            check("R7 trim", got_trim, m_trim);
            check("R8 precision", got_prec, m_prec);
        end
        check("R7 trim after result", int'(trim_word), m_trim);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1 trim", int'(trim_word), 0);
        check("R1 precision", int'(precision), 0);
        check("R1 phase_dev", int'(phase_dev), 0);
        check("R1 cal_state", int'(cal_state), 0);
        check("R1 result_ready", int'(result_ready), 0);

        // R3 unqualified at second 5 stays waiting
        cal_tick(5, 0, 0, "R3 unqualified wait");
        // R11 counter wraps after W centiseconds, prescale by DIV
        ticks(4802);
        cal_tick(5, 0, 0, "R11 wrap");
        ticks(1);
        cal_tick(7, 0, 0, "R11 prescale hold");
        ticks(1);
        cal_tick(7, 0, 0, "R11 prescale step");
        // R4 sweep of minute digits and seconds
        ticks(4400);
        for (int m = 0; m < 10; m++) begin
            for (int k = 0; k < 5; k++) begin
                int s;
                s = (k == 0) ? 0 : (k == 1) ? 4 : (k == 2) ? 6 : (k == 3) ? 31 : 59;
                ticks(13);
                cal_tick(s, m, 0, "R4 sweep");
            end
        end

        // R2 qualified follows sync
        set_sync(1);
        check("R2 qualified", int'(cal_state), 1);
        cal_tick(9, 1, 0, "R3 no start off second 5");
        cal_tick(5, 3, 0, "R3 start");
        cal_tick(8, 3, 0, "R3 counters cleared");

        // R5 finish by tau_min with |dev| >= 5
        ticks(974);
        cal_tick(5, 5, 0, "R5 finish dev 7");
        // R5 boundaries, then negative truncation toward zero
        cal_tick(5, 5, 0, "R3 restart");
        ticks(946);
        cal_tick(5, 7, 0, "R5 below tau_min");
        ticks(20);
        cal_tick(5, 7, 0, "R5 small dev");
        ticks(460);
        cal_tick(5, 8, 0, "R5 finish dev -7");
        // R5 finish by tau_max with small deviation
        cal_tick(5, 0, 0, "R3 restart");
        ticks(964);
        cal_tick(5, 2, 0, "R5 keep running");
        ticks(962);
        cal_tick(5, 4, 0, "R5 tau_max finish");
        // R7 clamp both directions
        cal_tick(5, 1, 0, "R3 restart");
        ticks(1000);
        cal_tick(5, 1, 0, "R7 clamp low");
        cal_tick(5, 6, 0, "R3 restart");
        ticks(1000);
        cal_tick(5, 0, 0, "R7 clamp high wrapped");

        // R6 unqualified running
        cal_tick(5, 2, 0, "R3 restart");
        set_sync(0);
        ticks(1000);
        cal_tick(5, 4, 0, "R6 keep running");
        ticks(1000);
        cal_tick(5, 6, 0, "R6 abort");

        // R9 leap second
        set_sync(1);
        cal_tick(5, 3, 0, "R3 restart");
        ticks(1000);
        cal_tick(5, 3, 1, "R9 leap");
        cal_tick(5, 3, 0, "R9 restart after leap");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule